// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block brings a small graphic display panel out of power-off and prepares it for normal drawing traffic. Once the chip's synchronous reset is released it runs a fixed timeline. It waits, pulses the panel's active-low reset line, and switches on the panel's high-voltage supply. It then lets the supply settle before it puts anything on the bus.

Once the panel is ready, the block sends a long run of zero data bytes through the bus writer to blank the whole frame memory. It then streams a short configuration list, held in a parameter ROM, as command bytes. Each byte is offered on a valid/ready handshake together with a data-or-command flag. When the last command byte has been accepted, the block raises `init_done` and goes quiet, and normal traffic can take over the bus writer.

The millisecond timing comes from a prescaler derived from the clock frequency and a tick rate. A simulation can therefore shrink every wait without touching the sequence.

Top module: `panel_init_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `pnl_rst_n`=1, `pnl_supply_en`=0, `bus_cs_n`=1, `wr_valid`=0, `wr_byte`=0x00, `wr_is_data`=0, `init_done`=0.
- R2: With D = CLK_HZ/TICK_HZ clock cycles per millisecond, `pnl_rst_n` falls at the edge PRE_MS·D cycles after reset release. It stays low for exactly RST_MS·D cycles and is then high until the next reset.
- R3: `pnl_supply_en` rises SUP_MS·D cycles after `pnl_rst_n` returns high and stays high until the next reset.
- R4: No byte is offered until SETTLE_MS·D cycles after the supply enable rises. `bus_cs_n` is low exactly while a byte is being offered, and high during every wait.
- R5: The clear phase offers exactly CLEAR_BYTES bytes, each with value 0x00 and `wr_is_data`=1.
- R6: After the last clear byte is accepted, the next offered byte is command entry 0. The CMD_LEN entries follow in index order with `wr_is_data`=0. Entry i sits in CMD_ROM bits [8i+7:8i].
- R7: A byte is accepted at an edge where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_byte` and `wr_is_data` hold their values.
- R8: `init_done` rises at the edge that accepts the last command entry. After that edge `wr_valid` is low and `bus_cs_n` is high, and `init_done` stays high until the next reset.
- R9: The default command list is 0x75,0x00,0x3F (row window), 0x15,0x00,0x3F (column window), 0x81,0x7F, 0xA0,0x41 (remap), 0xA2,0x44 (offset), 0xA4, and last the display-on code 0xAF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the sequence |
| wr_ready | input | 1 | Bus writer takes the offered byte at this edge |
| pnl_rst_n | output | 1 | Active-low reset line to the panel |
| pnl_supply_en | output | 1 | High enables the panel supply (shutdown control) |
| bus_cs_n | output | 1 | Panel chip select, active low |
| wr_valid | output | 1 | A byte is offered to the bus writer |
| wr_byte | output | 8 | Offered byte |
| wr_is_data | output | 1 | 1 = data byte, 0 = command byte |
| init_done | output | 1 | Bring-up finished, sticky until reset |

## Verification
The bench builds the block with CLK_HZ=10000 and TICK_HZ=1000, so one millisecond is 10 cycles. The full wait timeline then takes 460 cycles, and every phase boundary is compared to the cycle. The clear count and the command ROM keep their default values, so the full 5120-byte clear and the real command list are streamed under an irregular ready pattern. A reset in the middle of the clear shows that the timeline restarts from the beginning.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_PRE    = 3'd0,
    PH_RST    = 3'd1,
    PH_SUP    = 3'd2,
    PH_SETTLE = 3'd3,
    PH_CLEAR  = 3'd4,
    PH_CMD    = 3'd5,
    PH_DONE   = 3'd6
  } phase_t;
endpackage

// File: rtl/panel_init_tick.sv
// Millisecond prescaler: one-cycle tick every DIV cycles, restartable.
module panel_init_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/panel_init_ms_timer.sv
// Counts prescaler ticks and flags the tick that ends a wait of 'target' ms.
module panel_init_ms_timer #(
  parameter int MS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick,
  input  logic [MS_W-1:0] target,
  output logic            expire
);
  logic [MS_W-1:0] ms;

  assign expire = tick && (ms == target - MS_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) ms <= '0;
    else if (tick)  ms <= ms + MS_W'(1);
  end
endmodule

// File: rtl/panel_init_cmd_rom.sv
// Command list lookup; entry i lives in CONTENT[8i+7:8i].
module panel_init_cmd_rom #(
  parameter int                 LEN     = 2,
  parameter int                 IDX_W   = 2,
  parameter logic [LEN*8-1:0]   CONTENT = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       dout
);
  logic [7:0] tbl [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_ent
    assign tbl[g] = CONTENT[g*8 +: 8];
  end

  always_comb begin
    dout = 8'h00;
    for (int i = 0; i < LEN; i++) begin
      if (idx == IDX_W'(i)) dout = tbl[i];
    end
  end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_init_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TICK_HZ     = 1000,
  parameter int PRE_MS      = 2,
  parameter int RST_MS      = 2,
  parameter int SUP_MS      = 2,
  parameter int SETTLE_MS   = 40,
  parameter int CLEAR_BYTES = 80 * 64,
  parameter int CMD_LEN     = 14,
  parameter logic [CMD_LEN*8-1:0] CMD_ROM = {
    8'hAF, 8'hA4, 8'h44, 8'hA2, 8'h41, 8'hA0, 8'h7F,
    8'h81, 8'h3F, 8'h00, 8'h15, 8'h3F, 8'h00, 8'h75 }
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ready,
  output logic              pnl_rst_n,
  output logic              pnl_supply_en,
  output logic              bus_cs_n,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_is_data,
  output logic              init_done
);
  localparam int DIV    = CLK_HZ / TICK_HZ;
  localparam int MS_MAX = (SETTLE_MS > PRE_MS) ? SETTLE_MS : PRE_MS;
  localparam int MS_TOP = (MS_MAX > RST_MS) ? ((MS_MAX > SUP_MS) ? MS_MAX : SUP_MS)
                                            : ((RST_MS > SUP_MS) ? RST_MS : SUP_MS);
  localparam int MS_W   = $clog2(MS_TOP + 1);
  localparam int CLR_W  = $clog2(CLEAR_BYTES + 1);
  localparam int IDX_W  = $clog2(CMD_LEN + 1);

  phase_t            phase, phase_nxt;
  logic              tick, expire, advance, accept;
  logic [MS_W-1:0]   target;
  logic [CLR_W-1:0]  clr_cnt, clr_cnt_nxt;
  logic [IDX_W-1:0]  idx, idx_nxt;
  logic [BYTE_W-1:0] rom_byte;
  logic              offer_nxt;

  panel_init_tick #(.DIV(DIV)) u_tick (
    .clk (clk), .rst (rst), .clr (advance), .tick (tick)
  );

  panel_init_ms_timer #(.MS_W(MS_W)) u_timer (
    .clk (clk), .rst (rst), .clr (advance), .tick (tick),
    .target (target), .expire (expire)
  );

  panel_init_cmd_rom #(.LEN(CMD_LEN), .IDX_W(IDX_W), .CONTENT(CMD_ROM)) u_rom (
    .idx (idx_nxt), .dout (rom_byte)
  );

  assign accept = wr_valid && wr_ready;

  always_comb begin
    case (phase)
      PH_PRE:    target = MS_W'(PRE_MS);
      PH_RST:    target = MS_W'(RST_MS);
      PH_SUP:    target = MS_W'(SUP_MS);
      PH_SETTLE: target = MS_W'(SETTLE_MS);
      default:   target = MS_W'(1);
    endcase
  end

  always_comb begin
    phase_nxt   = phase;
    clr_cnt_nxt = clr_cnt;
    idx_nxt     = idx;
    case (phase)
      PH_PRE:    if (expire) phase_nxt = PH_RST;
      PH_RST:    if (expire) phase_nxt = PH_SUP;
      PH_SUP:    if (expire) phase_nxt = PH_SETTLE;
      PH_SETTLE: if (expire) phase_nxt = PH_CLEAR;
      PH_CLEAR: begin
        if (accept) begin
          clr_cnt_nxt = clr_cnt + CLR_W'(1);
          if (clr_cnt == CLR_W'(CLEAR_BYTES - 1)) phase_nxt = PH_CMD;
        end
      end
      PH_CMD: begin
        if (accept) begin
          idx_nxt = idx + IDX_W'(1);
          if (idx == IDX_W'(CMD_LEN - 1)) phase_nxt = PH_DONE;
        end
      end
      default: phase_nxt = PH_DONE;
    endcase
  end

  assign advance   = (phase_nxt != phase);
  assign offer_nxt = (phase_nxt == PH_CLEAR) || (phase_nxt == PH_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_PRE;
      clr_cnt       <= '0;
      idx           <= '0;
      pnl_rst_n     <= 1'b1;
      pnl_supply_en <= 1'b0;
      bus_cs_n      <= 1'b1;
      wr_valid      <= 1'b0;
      wr_byte       <= '0;
      wr_is_data    <= 1'b0;
      init_done     <= 1'b0;
    end else begin
      phase         <= phase_nxt;
      clr_cnt       <= clr_cnt_nxt;
      idx           <= idx_nxt;
      pnl_rst_n     <= (phase_nxt != PH_RST);
      pnl_supply_en <= (phase_nxt == PH_SETTLE) || offer_nxt || (phase_nxt == PH_DONE);
      bus_cs_n      <= !offer_nxt;
      wr_valid      <= offer_nxt;
      wr_byte       <= (phase_nxt == PH_CMD) ? rom_byte : '0;
      wr_is_data    <= (phase_nxt == PH_CLEAR);
      init_done     <= (phase_nxt == PH_DONE);
    end
  end
endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_ready,
  input logic       pnl_rst_n,
  input logic       pnl_supply_en,
  input logic       bus_cs_n,
  input logic       wr_valid,
  input logic [7:0] wr_byte,
  input logic       wr_is_data,
  input logic       init_done
);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_is_data)));

  assert_cs_matches_offer_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid != bus_cs_n);

  assert_offer_needs_power_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (pnl_supply_en && pnl_rst_n));

  assert_supply_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    pnl_supply_en |=> pnl_supply_en);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_is_data) |-> (wr_byte == 8'h00));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (!wr_valid && bus_cs_n));
endmodule

bind panel_init_seq panel_init_chk u_chk (
  .clk (clk), .rst (rst), .wr_ready (wr_ready),
  .pnl_rst_n (pnl_rst_n), .pnl_supply_en (pnl_supply_en), .bus_cs_n (bus_cs_n),
  .wr_valid (wr_valid), .wr_byte (wr_byte), .wr_is_data (wr_is_data),
  .init_done (init_done)
);

// File: tb/panel_init_seq_tb.sv
`timescale 1ns/1ps
module panel_init_seq_tb;
  localparam int D         = 10;
  localparam int PRE_C     = 2 * D;
  localparam int RST_C     = 2 * D;
  localparam int SUP_C     = 2 * D;
  localparam int SET_C     = 40 * D;
  localparam int NCLEAR    = 5120;
  localparam int NCMD      = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ready = 1'b0;
  logic       pnl_rst_n, pnl_supply_en, bus_cs_n, wr_valid, wr_is_data, init_done;
  logic [7:0] wr_byte;

  logic [7:0] exp_cmd [NCMD] = '{8'h75, 8'h00, 8'h3F, 8'h15, 8'h00, 8'h3F, 8'h81,
                                 8'h7F, 8'hA0, 8'h41, 8'hA2, 8'h44, 8'hA4, 8'hAF};

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int zeros_seen = 0;
  logic [7:0] cmd_seen [$];

  // behavioural reference: phase 0 pre,1 reset,2 supply wait,3 settle,4 clear,5 cmd,6 done
  int m_phase = 0;
  int m_wait  = PRE_C;
  int m_clr   = 0;
  int m_idx   = 0;

  always #5 clk = ~clk;

  panel_init_seq #(.CLK_HZ(10_000), .TICK_HZ(1000)) u_dut (
    .clk (clk), .rst (rst), .wr_ready (ready),
    .pnl_rst_n (pnl_rst_n), .pnl_supply_en (pnl_supply_en), .bus_cs_n (bus_cs_n),
    .wr_valid (wr_valid), .wr_byte (wr_byte), .wr_is_data (wr_is_data),
    .init_done (init_done)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_wait = PRE_C; m_clr = 0; m_idx = 0;
    end else begin
      case (m_phase)
        0, 1, 2, 3: begin
          m_wait = m_wait - 1;
          if (m_wait == 0) begin
            m_phase = m_phase + 1;
            m_wait = (m_phase == 1) ? RST_C : (m_phase == 2) ? SUP_C : SET_C;
          end
        end
        4: if (ready) begin
          m_clr = m_clr + 1;
          if (m_clr == NCLEAR) m_phase = 5;
        end
        5: if (ready) begin
          m_idx = m_idx + 1;
          if (m_idx == NCMD) m_phase = 6;
        end
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    bit e_valid;
    @(negedge clk);
    cyc++;
    e_valid = (m_phase == 4) || (m_phase == 5);
    check(pnl_rst_n == (m_phase != 1), "R2 pnl_rst_n", pnl_rst_n, m_phase != 1);
    check(pnl_supply_en == (m_phase >= 3), "R3 pnl_supply_en", pnl_supply_en, m_phase >= 3);
    check(bus_cs_n == !e_valid, "R4 bus_cs_n", bus_cs_n, !e_valid);
    check(wr_valid == e_valid, "R7 wr_valid", wr_valid, e_valid);
    check(wr_is_data == (m_phase == 4), "R5 wr_is_data", wr_is_data, m_phase == 4);
    if (m_phase == 5)
      check(wr_byte == exp_cmd[m_idx], "R6 wr_byte", wr_byte, exp_cmd[m_idx]);
    else
      check(wr_byte == 8'h00, "R5 wr_byte", wr_byte, 0);
    check(init_done == (m_phase == 6), "R8 init_done", init_done, m_phase == 6);
    ready = ($urandom % 4) != 0;
    if (wr_valid && ready) begin
      if (wr_is_data && wr_byte == 8'h00) zeros_seen++;
      if (!wr_is_data) cmd_seen.push_back(wr_byte);
    end
  endtask

  initial begin
    bit hung = 0;
    rst = 1'b1;
    repeat (3) step();
    // R1 reset state
    check(pnl_rst_n && !pnl_supply_en && bus_cs_n && !wr_valid && !init_done && wr_byte == 0,
          "R1 reset state", {pnl_rst_n, pnl_supply_en, bus_cs_n, wr_valid, init_done}, 5'b10100);
    rst = 1'b0;
    // run into the clear phase, then reset mid-stream
    repeat (PRE_C + RST_C + SUP_C + SET_C + 300) step();
    check(wr_valid && wr_is_data, "R5 clear under way", wr_valid, 1);
    rst = 1'b1;
    repeat (2) step();
    check(pnl_rst_n && !pnl_supply_en && bus_cs_n && !wr_valid && !init_done,
          "R1 mid-run reset", {pnl_rst_n, pnl_supply_en, bus_cs_n, wr_valid, init_done}, 5'b10100);
    zeros_seen = 0;
    cmd_seen.delete();
    rst = 1'b0;
    // R2/R3 phase edges from release
    repeat (PRE_C - 1) step();
    check(pnl_rst_n == 1'b1, "R2 before reset pulse", pnl_rst_n, 1);
    step();
    check(pnl_rst_n == 1'b0, "R2 reset pulse start", pnl_rst_n, 0);
    repeat (RST_C) step();
    check(pnl_rst_n == 1'b1, "R2 reset pulse end", pnl_rst_n, 1);
    repeat (SUP_C) step();
    check(pnl_supply_en == 1'b1, "R3 supply on", pnl_supply_en, 1);
    repeat (SET_C - 1) step();
    check(wr_valid == 1'b0 && bus_cs_n, "R4 settle quiet", wr_valid, 0);
    step();
    check(wr_valid == 1'b1 && !bus_cs_n, "R4 first offer", wr_valid, 1);
    for (int n = 0; n < 100000 && !init_done; n++) step();
    if (!init_done) begin
      hung = 1;
      fails++; checks++;
      $display("FAIL R8 watchdog: init_done never rose, actual 0 expected 1");
    end
    if (!hung) begin
      repeat (40) step();
      check(init_done, "R8 done held", init_done, 1);
      check(zeros_seen == NCLEAR, "R5 zero byte count", zeros_seen, NCLEAR);
      check(cmd_seen.size() == NCMD, "R6 command count", cmd_seen.size(), NCMD);
      if (cmd_seen.size() == NCMD) begin
        for (int i = 0; i < NCMD; i++)
          check(cmd_seen[i] == exp_cmd[i], "R6 command order", cmd_seen[i], exp_cmd[i]);
        check(cmd_seen[0] == 8'h75 && cmd_seen[3] == 8'h15, "R9 window commands", cmd_seen[0], 8'h75);
        check(cmd_seen[8] == 8'hA0 && cmd_seen[9] == 8'h41, "R9 remap pair", cmd_seen[9], 8'h41);
        check(cmd_seen[10] == 8'hA2 && cmd_seen[11] == 8'h44, "R9 offset pair", cmd_seen[11], 8'h44);
        check(cmd_seen[NCMD-1] == 8'hAF, "R9 display on last", cmd_seen[NCMD-1], 8'hAF);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule